// File: doc/BRIEF.md
# Protected Device Configuration Register File

This block holds a small set of 32-bit device configuration registers behind a simple one-cycle bus with per-byte write strobes. A write is a full word (strobe `1111`) or a halfword (`0011` low half, `1100` high half). Each register enforces its own write policy in hardware rather than acting as plain storage:

- The revision field may be written only once after reset.
- The trim error status freezes once it holds a non-zero value.
- The soft-reset groups and the capture-type selector need a protected-write enable input.
- The capture-type selector can lock itself.
- The boundary-scan disable bit changes only on a keyed full-word write.

Boot firmware fills the identification fields once. Run-time software then drives the per-module soft resets and the capture and scan controls. Every write the block refuses raises a one-cycle error pulse. Reads are combinational while a read request is present and return 0 otherwise.

Top module: `devcfg_regfile`

## Requirements
- R1: The revision register (word index 0, bits 15:0) accepts only the first write after reset that strobes at least one of bytes 0..1. That write updates only its strobed bytes and consumes the one opportunity even if the data is zero. Every later write is refused and leaves the value unchanged.
- R2: The trim status register (index 1, bits 15:0) takes strobed bytes for as long as its value is zero. Once it holds a non-zero value, every further write is refused.
- R3: In the capture register (index 5), bit 15 is a lock. It is set by an accepted write with byte 1 strobed and data bit 15 high. A write of 0 never clears it. While the lock is 1, every write to index 5 is refused and the type field keeps its value.
- R4: The capture type field sits in bits 1:0 of index 5 and is written when byte 0 is strobed. `cap_protected_o` is high only when the type is `01`. The types `00`, `10` and `11` keep it low.
- R5: The soft-reset groups sit at indices 2, 3 and 4, bits 15:0. Their implemented-bit masks are `03FF`, `FFFF` and `00FF`. An accepted write loads the strobed bytes ANDed with the mask. Unimplemented bits read 0. Group g drives `soft_rst_o[16g+15:16g]`. A bit set to 1 stays set until software writes it to 0.
- R6: Writes to indices 2, 3, 4 and 5 are refused while `prot_wr_en` is low.
- R7: The scan disable bit (index 6, bit 0) changes only on a write with strobe `1111` and data bits 31:16 equal to `A5A5`. Any other write to index 6, including either halfword, is refused. `bscan_dis_o` follows the bit.
- R8: Key bits and reserved bits read as 0. Index 6 reads back only bit 0, and the other indices read back only the fields listed above.
- R9: A read of an index from 7 upward returns 0. A write to such an index changes nothing and is refused.
- R10: `wr_err_o` is high for exactly the cycle after each refused write and is low after accepted writes and reads.
- R11: Reset (synchronous, active low) clears every register, including the once flags and the lock, so the revision register can be written once again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Word index |
| bus_strb | input | 4 | Byte write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| prot_wr_en | input | 1 | Protected-write enable |
| wr_err_o | output | 1 | One-cycle pulse after a refused write |
| soft_rst_o | output | 3*SRST_W (48) | Sticky per-module reset outputs |
| cap_protected_o | output | 1 | Capture type selects protected mode |
| bscan_dis_o | output | 1 | Boundary-scan control disabled |

## Verification
Directed sequences cover the following corner cases:
- A zero first write to each once-field, which shows the write-once and set-once flavours behave differently.
- Half-word and wrong-key writes to the scan register, which separate the key check from the strobe check.
- Lock-then-write sequences on the capture register.
- Enable-low writes to the protected registers.

Randomized traffic then mixes all indices, the strobe shapes, key hits and misses, and enable levels. This shows whether acceptance depends on the exact combination of address, strobe, data and enable. A mid-run reset shows that every once flag and the lock return to their initial state.

// File: rtl/devcfg_pkg.sv
// Shared constants and helpers for the device configuration register file.
// Assumes a 32-bit bus with byte strobes; the low half carries every field.
package devcfg_pkg;
    localparam int unsigned BUS_W   = 32;
    localparam int unsigned STRB_W  = BUS_W / 8;
    localparam int unsigned HALF_W  = BUS_W / 2;
    localparam int unsigned HALF_BE = HALF_W / 8;
    localparam int unsigned NUM_SRST = 3;

    localparam logic [HALF_W-1:0] SCAN_KEY = 16'hA5A5;
    localparam logic [1:0]        CAP_PROT_CODE = 2'b01;

    // word indices; the soft-reset groups are consecutive
    localparam int unsigned IDX_REV   = 0;
    localparam int unsigned IDX_TRIM  = 1;
    localparam int unsigned IDX_SRST0 = 2;
    localparam int unsigned IDX_CAP   = IDX_SRST0 + NUM_SRST;
    localparam int unsigned IDX_SCAN  = IDX_CAP + 1;

    localparam int unsigned CAP_LOCK_BIT = 15;
endpackage

// File: rtl/cfg_once_field.sv
// One-shot field. SET_ONCE=0: the first write freezes it regardless of data.
// SET_ONCE=1: it stays writable while zero and freezes once non-zero.
// Assumes wr_hit already includes address decode and at least one strobe.
module cfg_once_field #(
    parameter int unsigned W        = 16,
    parameter bit          SET_ONCE = 1'b0,
    localparam int unsigned NB      = W / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic [W-1:0]  wdata,
    input  logic [NB-1:0] wbe,
    output logic          accept,
    output logic [W-1:0]  q
);
    logic frozen;

    generate
        if (SET_ONCE) begin : g_set_once
            // non-zero content is the freeze condition
            assign frozen = |q;
        end else begin : g_write_once
            logic done_q;
            // remembers that the single permitted write has happened
            always_ff @(posedge clk) begin
                if (!rst_n)      done_q <= 1'b0;
                else if (accept) done_q <= 1'b1;
            end
            assign frozen = done_q;
        end
    endgenerate

    assign accept = wr_hit && !frozen;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        // byte lane update on an accepted strobed write
        always_ff @(posedge clk) begin
            if (!rst_n)                q[b*8 +: 8] <= '0;
            else if (accept && wbe[b]) q[b*8 +: 8] <= wdata[b*8 +: 8];
        end
    end
endmodule

// File: rtl/cfg_srst_group.sv
// Sticky soft-reset group: bits hold until rewritten; unimplemented bits
// (MASK=0) stay 0. Assumes wr_en already carries decode and protection.
module cfg_srst_group #(
    parameter int unsigned     W    = 16,
    parameter logic [W-1:0]    MASK = '1,
    localparam int unsigned    NB   = W / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wdata,
    input  logic [NB-1:0] wbe,
    output logic [W-1:0]  q
);
    for (genvar b = 0; b < NB; b++) begin : g_byte
        // masked byte lane load; no self clearing
        always_ff @(posedge clk) begin
            if (!rst_n)               q[b*8 +: 8] <= '0;
            else if (wr_en && wbe[b]) q[b*8 +: 8] <= wdata[b*8 +: 8] & MASK[b*8 +: 8];
        end
    end
endmodule

// File: rtl/devcfg_regfile.sv
// Device configuration register file with hardware-enforced write policies.
// Assumes single-cycle requests (bus_sel) and combinational read data.
module devcfg_regfile
    import devcfg_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned SRST_W = 16,
    parameter logic [NUM_SRST*SRST_W-1:0] SRST_MASKS = {16'h00FF, 16'hFFFF, 16'h03FF},
    localparam int unsigned SRST_BE = SRST_W / 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [STRB_W-1:0]          bus_strb,
    input  logic [BUS_W-1:0]           bus_wdata,
    output logic [BUS_W-1:0]           bus_rdata,
    input  logic                       prot_wr_en,
    output logic                       wr_err_o,
    output logic [NUM_SRST*SRST_W-1:0] soft_rst_o,
    output logic                       cap_protected_o,
    output logic                       bscan_dis_o
);
    logic              wr_req, rd_req, lo_touch;
    logic              is_rev, is_trim, is_cap, is_scan;
    logic [NUM_SRST-1:0] is_srst;
    logic              rev_acc, trim_acc, cap_ok, scan_ok, reject;
    logic [HALF_W-1:0] rev_q, trim_q;
    logic              cap_lock_q;
    logic [1:0]        cap_type_q;
    logic              scan_q;
    logic              err_q;

    assign wr_req   = bus_sel && bus_wr;
    assign rd_req   = bus_sel && !bus_wr;
    assign lo_touch = |bus_strb[HALF_BE-1:0];
    assign is_rev   = (bus_addr == ADDR_W'(IDX_REV));
    assign is_trim  = (bus_addr == ADDR_W'(IDX_TRIM));
    assign is_cap   = (bus_addr == ADDR_W'(IDX_CAP));
    assign is_scan  = (bus_addr == ADDR_W'(IDX_SCAN));

    cfg_once_field #(.W(HALF_W), .SET_ONCE(1'b0)) u_rev (
        .clk(clk), .rst_n(rst_n),
        .wr_hit(wr_req && is_rev && lo_touch),
        .wdata(bus_wdata[HALF_W-1:0]), .wbe(bus_strb[HALF_BE-1:0]),
        .accept(rev_acc), .q(rev_q)
    );

    cfg_once_field #(.W(HALF_W), .SET_ONCE(1'b1)) u_trim (
        .clk(clk), .rst_n(rst_n),
        .wr_hit(wr_req && is_trim && lo_touch),
        .wdata(bus_wdata[HALF_W-1:0]), .wbe(bus_strb[HALF_BE-1:0]),
        .accept(trim_acc), .q(trim_q)
    );

    for (genvar g = 0; g < NUM_SRST; g++) begin : g_srst
        assign is_srst[g] = (bus_addr == ADDR_W'(IDX_SRST0 + g));
        cfg_srst_group #(.W(SRST_W), .MASK(SRST_MASKS[g*SRST_W +: SRST_W])) u_grp (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wr_req && is_srst[g] && prot_wr_en),
            .wdata(bus_wdata[SRST_W-1:0]), .wbe(bus_strb[SRST_BE-1:0]),
            .q(soft_rst_o[g*SRST_W +: SRST_W])
        );
    end

    assign cap_ok  = wr_req && is_cap && prot_wr_en && !cap_lock_q;
    assign scan_ok = wr_req && is_scan && (bus_strb == '1) &&
                     (bus_wdata[BUS_W-1:HALF_W] == SCAN_KEY);

    // capture selector: type by byte 0, set-once lock by byte 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_type_q <= '0;
            cap_lock_q <= 1'b0;
        end else if (cap_ok) begin
            if (bus_strb[0]) cap_type_q <= bus_wdata[1:0];
            if (bus_strb[1] && bus_wdata[CAP_LOCK_BIT]) cap_lock_q <= 1'b1;
        end
    end

    // keyed scan disable bit
    always_ff @(posedge clk) begin
        if (!rst_n)       scan_q <= 1'b0;
        else if (scan_ok) scan_q <= bus_wdata[0];
    end

    // classify the current write as refused or not
    always_comb begin
        if (is_rev)           reject = !rev_acc;
        else if (is_trim)     reject = !trim_acc;
        else if (|is_srst)    reject = !prot_wr_en;
        else if (is_cap)      reject = !cap_ok;
        else if (is_scan)     reject = !scan_ok;
        else                  reject = 1'b1;
        reject = reject && wr_req;
    end

    // one-cycle error pulse after a refused write
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= reject;
    end

    // read mux: fields only, keys and reserved bits as zero
    always_comb begin
        bus_rdata = '0;
        if (rd_req) begin
            if (is_rev)       bus_rdata[HALF_W-1:0] = rev_q;
            else if (is_trim) bus_rdata[HALF_W-1:0] = trim_q;
            else if (is_cap) begin
                bus_rdata[CAP_LOCK_BIT] = cap_lock_q;
                bus_rdata[1:0]          = cap_type_q;
            end
            else if (is_scan) bus_rdata[0] = scan_q;
            else begin
                for (int g = 0; g < NUM_SRST; g++)
                    if (is_srst[g]) bus_rdata[SRST_W-1:0] = soft_rst_o[g*SRST_W +: SRST_W];
            end
        end
    end

    assign wr_err_o        = err_q;
    assign cap_protected_o = (cap_type_q == CAP_PROT_CODE);
    assign bscan_dis_o     = scan_q;
endmodule

// File: rtl/devcfg_regfile_chk.sv
// Property checker for devcfg_regfile, attached by bind below.
// Assumes reset is asserted from time zero.
module devcfg_regfile_chk #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned OUT_W  = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]        bus_strb,
    input logic [31:0]       bus_wdata,
    input logic              prot_wr_en,
    input logic              wr_err_o,
    input logic [OUT_W-1:0]  soft_rst_o,
    input logic              bscan_dis_o,
    input logic [15:0]       rev_q,
    input logic              cap_lock_q,
    input logic [1:0]        cap_type_q
);
    logic rev_seen_q;

    // tracks that the revision register has taken its one write
    always_ff @(posedge clk) begin
        if (!rst_n) rev_seen_q <= 1'b0;
        else if (bus_sel && bus_wr && bus_addr == '0 && |bus_strb[1:0]) rev_seen_q <= 1'b1;
    end

    p_rev_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rev_seen_q |=> $stable(rev_q));

    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_lock_q |=> (cap_lock_q && $stable(cap_type_q)));

    p_srst_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(soft_rst_o) |-> $past(bus_sel && bus_wr && prot_wr_en));

    p_scan_keyed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bscan_dis_o) |-> $past(bus_sel && bus_wr && bus_strb == 4'hF &&
                                        bus_wdata[31:16] == 16'hA5A5));

    p_err_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err_o |-> $past(bus_sel && bus_wr));
endmodule

bind devcfg_regfile devcfg_regfile_chk #(.ADDR_W(ADDR_W), .OUT_W(devcfg_pkg::NUM_SRST*SRST_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_strb(bus_strb), .bus_wdata(bus_wdata),
    .prot_wr_en(prot_wr_en), .wr_err_o(wr_err_o), .soft_rst_o(soft_rst_o),
    .bscan_dis_o(bscan_dis_o), .rev_q(rev_q), .cap_lock_q(cap_lock_q),
    .cap_type_q(cap_type_q)
);

// File: tb/devcfg_regfile_tb.sv
module devcfg_regfile_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, prot_wr_en = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [3:0]  bus_strb = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wr_err_o, cap_protected_o, bscan_dis_o;
    logic [47:0] soft_rst_o;

    int checks = 0, errors = 0;

    // model state
    logic [15:0] m_rev, m_trim, m_s0, m_s1, m_s2;
    logic        m_rev_done, m_lock, m_scan;
    logic [1:0]  m_type;

    always #4 clk = ~clk;

    devcfg_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_strb(bus_strb), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .prot_wr_en(prot_wr_en), .wr_err_o(wr_err_o),
        .soft_rst_o(soft_rst_o), .cap_protected_o(cap_protected_o),
        .bscan_dis_o(bscan_dis_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                          input logic [1:0] be);
        merge = old;
        for (int b = 0; b < 2; b++) if (be[b]) merge[b*8 +: 8] = d[b*8 +: 8];
    endfunction

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        case (a)
            4'd0: exp_read = {16'h0, m_rev};
            4'd1: exp_read = {16'h0, m_trim};
            4'd2: exp_read = {16'h0, m_s0};
            4'd3: exp_read = {16'h0, m_s1};
            4'd4: exp_read = {16'h0, m_s2};
            4'd5: exp_read = {16'h0, m_lock, 13'h0, m_type};
            4'd6: exp_read = {31'h0, m_scan};
            default: exp_read = '0;
        endcase
    endfunction

    task automatic model_clear();
        m_rev = '0; m_trim = '0; m_s0 = '0; m_s1 = '0; m_s2 = '0;
        m_rev_done = 1'b0; m_lock = 1'b0; m_scan = 1'b0; m_type = '0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; bus_sel = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        model_clear();
    endtask

    task automatic chk_outs(input string req);
        chk({req, " soft_rst_o"}, 64'(soft_rst_o), 64'({m_s2, m_s1, m_s0}));
        chk({req, " cap_protected_o"}, 64'(cap_protected_o), 64'(m_type == 2'b01));
        chk({req, " bscan_dis_o"}, 64'(bscan_dis_o), 64'(m_scan));
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s,
                      input logic p, input string req);
        logic e;
        logic [15:0] nv;
        e = 1'b0;
        case (a)
            4'd0: if (|s[1:0] && !m_rev_done) begin m_rev = merge(m_rev, d[15:0], s[1:0]); m_rev_done = 1'b1; end
                  else e = 1'b1;
            4'd1: if (|s[1:0] && m_trim == 16'h0) m_trim = merge(m_trim, d[15:0], s[1:0]);
                  else e = 1'b1;
            4'd2, 4'd3, 4'd4: if (p) begin
                      if (a == 4'd2) begin nv = merge(m_s0, d[15:0], s[1:0]); m_s0 = nv & 16'h03FF; end
                      if (a == 4'd3) begin nv = merge(m_s1, d[15:0], s[1:0]); m_s1 = nv; end
                      if (a == 4'd4) begin nv = merge(m_s2, d[15:0], s[1:0]); m_s2 = nv & 16'h00FF; end
                  end else e = 1'b1;
            4'd5: if (p && !m_lock) begin
                      if (s[0]) m_type = d[1:0];
                      if (s[1] && d[15]) m_lock = 1'b1;
                  end else e = 1'b1;
            4'd6: if (s == 4'hF && d[31:16] == 16'hA5A5) m_scan = d[0];
                  else e = 1'b1;
            default: e = 1'b1;
        endcase
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_strb = s; prot_wr_en = p;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
        chk({req, " wr_err_o"}, 64'(wr_err_o), 64'(e));
        chk_outs(req);
    endtask

    task automatic rd(input logic [3:0] a, input string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 chk({req, " rdata"}, 64'(bus_rdata), 64'(exp_read(a)));
        @(posedge clk); #1;
        bus_sel = 1'b0;
        chk({req, " wr_err_o after read"}, 64'(wr_err_o), 64'h0);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0]  a, s;
        logic [31:0] d;
        void'($urandom(32'd1234));
        model_clear();
        do_reset();
        // R11: reset state
        for (int i = 0; i < 8; i++) rd(4'(i), "R11 reset value");
        chk_outs("R11 reset outputs");
        chk("R11 wr_err reset", 64'(wr_err_o), 64'h0);

        // R1: write-once revision, zero first write still consumes it
        wr(4'd0, 32'hFFFF_0000, 4'h3, 1'b0, "R1 first write zero");
        wr(4'd0, 32'h0000_1234, 4'h3, 1'b0, "R1 second write refused");
        rd(4'd0, "R1 value held");
        // R2: set-once trim stays writable while zero
        wr(4'd1, 32'h0, 4'h3, 1'b0, "R2 zero write accepted");
        wr(4'd1, 32'h0000_0020, 4'h1, 1'b0, "R2 nonzero write");
        wr(4'd1, 32'h0000_0001, 4'h3, 1'b0, "R2 frozen");
        rd(4'd1, "R2 value held");
        // R6 / R5: protected soft resets, masks, stickiness
        wr(4'd2, 32'h0000_FFFF, 4'h3, 1'b0, "R6 enable low refused");
        wr(4'd2, 32'h0000_FFFF, 4'hF, 1'b1, "R5 mask group0");
        wr(4'd4, 32'hFFFF_FFFF, 4'hF, 1'b1, "R5 mask group2");
        repeat (5) @(posedge clk);
        #1 chk_outs("R5 sticky");
        wr(4'd2, 32'h0000_0000, 4'h1, 1'b1, "R5 clear low byte");
        rd(4'd2, "R5 partial clear");
        // R4 / R3: capture type and lock
        wr(4'd5, 32'h1, 4'h1, 1'b1, "R4 type 01");
        wr(4'd5, 32'h2, 4'h1, 1'b0, "R6 cap enable low");
        wr(4'd5, 32'h0000_8003, 4'h3, 1'b1, "R3 set lock with type 11");
        wr(4'd5, 32'h1, 4'h1, 1'b1, "R3 locked write refused");
        wr(4'd5, 32'h0, 4'h3, 1'b1, "R3 lock not clearable");
        rd(4'd5, "R3 readback");
        // R7: keyed scan disable
        wr(4'd6, 32'hA5A5_0001, 4'hF, 1'b0, "R7 keyed set");
        wr(4'd6, 32'hA5A5_0000, 4'h3, 1'b0, "R7 low half refused");
        wr(4'd6, 32'hA5A5_0000, 4'hC, 1'b0, "R7 high half refused");
        wr(4'd6, 32'hA5A4_0000, 4'hF, 1'b0, "R7 wrong key");
        rd(4'd6, "R8 key reads zero");
        wr(4'd6, 32'hA5A5_0000, 4'hF, 1'b0, "R7 keyed clear");
        // R9: unmapped
        wr(4'd9, 32'hFFFF_FFFF, 4'hF, 1'b1, "R9 unmapped write");
        rd(4'd9, "R9 unmapped read");
        rd(4'd15, "R9 unmapped read top");
        // R11: second reset reopens once fields and lock
        do_reset();
        wr(4'd0, 32'h0000_00AB, 4'h1, 1'b0, "R11 rev writable again");
        rd(4'd0, "R11 rev value");
        wr(4'd5, 32'h2, 4'h1, 1'b1, "R11 lock cleared");

        // random mix, R10 checked on every write
        for (int n = 0; n < 500; n++) begin
            if (n == 250) do_reset();
            a = 4'($urandom_range(0, 8));
            case ($urandom_range(0, 4))
                0: s = 4'hF; 1: s = 4'h3; 2: s = 4'hC; 3: s = 4'h1;
                default: s = 4'($urandom);
            endcase
            d = $urandom;
            if ($urandom_range(0, 2) == 0) d[31:16] = 16'hA5A5;
            if ($urandom_range(0, 3) != 0 && a == 4'd1) d[15:0] = 16'h0;
            if ($urandom_range(0, 1) == 0) wr(a, d, s, 1'($urandom), "R10 random write");
            else rd(a, "R8 random read");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule